// File: doc/BRIEF.md
# Dual-Channel Low-Power PWM Timer

This block generates two pulse-width-modulated outputs from one shared time base. A power-of-two prescaler divides the clock into ticks, and an up-counter advances on each tick and returns to zero after it reaches the reload value. Each channel compares the counter against its own compare value. It drives its active level while the counter is above that value. Software picks the period by the reload value and the duty by the compare value. For a duty of D ticks it writes compare = reload − D.

Software sees a register port with one write per cycle and a combinational read. Timer state gates the writes. The prescaler and output polarity can only be configured while the timer is off. Reload and compare values are only accepted while it is on. Each accepted reload or compare write later raises its own sticky completion flag, which software clears by writing a 1. Each channel has its own enable bit and polarity bit. A polarity bit cannot change while its channel is enabled. After any channel-mode write, the channel-mode register is locked for three prescaled clock periods.

The control path is a three-state machine. `TS_OFF` goes to `TS_ARMED` on a control write with enable set. `TS_ARMED` goes to `TS_RUN` on a control write with both enable and start set. Either enabled state returns to `TS_OFF` on a control write with enable clear. Each completion flag has a tracker that steps from `WF_IDLE` to `WF_WAIT2` on an accepted write. It moves to `WF_WAIT1` on the next tick and back to `WF_IDLE` on the tick after that, which sets the flag. The channel-mode guard moves from `GS_READY` to `GS_HOLD` on an accepted write and returns when its clock count runs out. With `SINGLE_OUT` set, only one output exists and its polarity comes from the configuration register.

Top module: `lpt_timer`

## Requirements
- R1: After reset every readable register reads 0, all completion flags and the busy bit are clear, and both outputs are low.
- R2: Control register (address 0): a write with bit0=1 enables the timer. Bit1=1 in a write starts counting only if the timer was already enabled before that write. A write with bit0=0 stops the timer, zeroes the counter and cancels any pending completion. A read returns bit0=enabled and bit1=counting.
- R3: Configuration register (address 1) bits[2:0] hold N. The counter advances once every 2^N clock cycles, for N from 0 to 7.
- R4: The counter counts 0..reload (address 2) and then wraps to 0, so one output period is (reload+1)·2^N clock cycles.
- R5: An enabled channel is active while the counter is strictly greater than its compare value (channel A at address 3, channel B at address 4). That gives reload − compare active ticks per period.
- R6: Writes to the configuration register while the timer is enabled are ignored.
- R7: Writes to the reload and compare registers while the timer is disabled are ignored.
- R8: Status register (address 6): bit0 reload-done, bit1 compare-A-done, bit2 compare-B-done. An accepted write sets its bit on the second prescaler tick after the write cycle.
- R9: Completion flags stay set until a write to address 7 has a 1 in the matching bit (bits 0..2). A flag being set wins over a clear in the same cycle. Address 7 reads 0.
- R10: Reload and compare values written while counting take effect at the next counter wrap. While not counting they take effect at once.
- R11: Channel-mode register (address 5): bit0 A enable, bit1 A polarity, bit2 B enable, bit3 B polarity. A disabled channel outputs its polarity bit, which is its inactive level. Polarity 1 inverts an enabled channel.
- R12: In a channel-mode write, a channel's polarity bit is ignored while that channel is currently enabled. Its enable bit is still taken.
- R13: After an accepted channel-mode write, further channel-mode writes are ignored for 3·2^N clock cycles. Status bit3 reads 1 during that time.
- R14: With `SINGLE_OUT`=1, output A is always enabled and takes its polarity from configuration bit3, channel-mode writes are ignored, and output B stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data of the addressed register |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The bench builds two instances with an 8-bit counter and a shared bus. One uses the default two-channel variant and the other sets `SINGLE_OUT`=1. The narrow counter keeps full periods short, even at the largest prescale of 128, so duty windows can be counted over whole periods. The single-output instance runs next to the dual one to show that its polarity comes from configuration bit3 rather than the channel-mode bits. Small prescale values make the two-tick completion latency and the 3·2^N channel-mode lock line up with individual clock edges.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int PSC_W    = 3;
    localparam int DIV_W    = (1 << PSC_W) - 1;
    localparam int NUM_CH   = 2;
    localparam int NUM_FLAG = 3;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_CFG    = 3'd1;
    localparam logic [2:0] RA_RELOAD = 3'd2;
    localparam logic [2:0] RA_CMPA   = 3'd3;
    localparam logic [2:0] RA_CMPB   = 3'd4;
    localparam logic [2:0] RA_CHMODE = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd6;
    localparam logic [2:0] RA_CLEAR  = 3'd7;

    typedef enum logic [1:0] {
        TS_OFF   = 2'd0,
        TS_ARMED = 2'd1,
        TS_RUN   = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        WF_IDLE  = 2'd0,
        WF_WAIT2 = 2'd1,
        WF_WAIT1 = 2'd2
    } wflag_state_e;

    typedef enum logic {
        GS_READY = 1'b0,
        GS_HOLD  = 1'b1
    } guard_state_e;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;

    always_comb begin
        span  = (DIV_W+1)'(1) << psc_i;
        limit = DIV_W'(span - (DIV_W+1)'(1));
    end

    assign tick_o = run_i && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/lpt_wrflag.sv
module lpt_wrflag
    import lpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic clear_i,
    output logic flag_o
);

    wflag_state_e st_q, st_d;
    logic         done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (flush_i) begin
            st_d = WF_IDLE;
        end else if (start_i) begin
            st_d = WF_WAIT2;
        end else begin
            unique case (st_q)
                WF_IDLE:  st_d = WF_IDLE;
                WF_WAIT2: if (tick_i) st_d = WF_WAIT1;
                WF_WAIT1: begin
                    if (tick_i) begin
                        st_d = WF_IDLE;
                        done = 1'b1;
                    end
                end
                default:  st_d = WF_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WF_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (done) begin
            flag_o <= 1'b1;
        end else if (clear_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lpt_chm_guard.sv
module lpt_chm_guard
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             busy_o
);

    localparam int HOLD_W = DIV_W + 3;

    guard_state_e      st_q, st_d;
    logic [HOLD_W-1:0] left_q, left_d;

    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            GS_READY: begin
                if (arm_i) begin
                    st_d   = GS_HOLD;
                    left_d = HOLD_W'(3) << psc_i;
                end
            end
            GS_HOLD: begin
                if (left_q == HOLD_W'(1)) begin
                    st_d   = GS_READY;
                    left_d = '0;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: begin
                st_d   = GS_READY;
                left_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= GS_READY;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    assign busy_o = (st_q == GS_HOLD);

endmodule

// File: rtl/lpt_chan.sv
module lpt_chan #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             en_i,
    input  logic             pol_i,
    output logic             out_o
);

    logic active;

    assign active = (cnt_i > cmp_i);
    assign out_o  = en_i ? (active ^ pol_i) : pol_i;

endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit SINGLE_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int CHM_W = 2 * NUM_CH;

    tmr_state_e state_q, state_d;
    logic       en, running, tick, stop_req, wrap;
    logic [7:0] wr_hit;

    logic [PSC_W-1:0]    psc_q;
    logic                opol_q;
    logic [CNT_W-1:0]    rld_sh_q, rld_act_q, cnt_q;
    logic [CNT_W-1:0]    cmp_sh_q  [NUM_CH];
    logic [CNT_W-1:0]    cmp_act_q [NUM_CH];
    logic                ld_rld;
    logic [NUM_CH-1:0]   ld_cmp;
    logic [NUM_FLAG-1:0] flag_start, flags;
    logic [CHM_W-1:0]    chm_q;
    logic                chm_busy;

    assign wr_hit = bus_we ? (8'd1 << bus_addr) : 8'd0;

    // ---------------- control state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_OFF: begin
                if (wr_hit[RA_CTRL] && bus_wdata[0]) state_d = TS_ARMED;
            end
            TS_ARMED: begin
                if (wr_hit[RA_CTRL]) begin
                    if (!bus_wdata[0])     state_d = TS_OFF;
                    else if (bus_wdata[1]) state_d = TS_RUN;
                end
            end
            TS_RUN: begin
                if (wr_hit[RA_CTRL] && !bus_wdata[0]) state_d = TS_OFF;
            end
            default: state_d = TS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign en       = (state_q != TS_OFF);
    assign running  = (state_q == TS_RUN);
    assign stop_req = wr_hit[RA_CTRL] && !bus_wdata[0];

    // ---------------- configuration ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            opol_q <= 1'b0;
        end else if (wr_hit[RA_CFG] && !en) begin
            psc_q  <= bus_wdata[PSC_W-1:0];
            opol_q <= bus_wdata[PSC_W];
        end
    end

    lpt_prescaler u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (en),
        .psc_i  (psc_q),
        .tick_o (tick)
    );

    // ---------------- reload / compare shadows ----------------
    assign ld_rld = wr_hit[RA_RELOAD] && en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_sh_q <= '0;
        end else if (ld_rld) begin
            rld_sh_q <= bus_wdata;
        end
    end

    assign wrap = (cnt_q == rld_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_act_q <= '0;
        end else if (!running || (tick && wrap)) begin
            rld_act_q <= rld_sh_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!running || stop_req) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        localparam logic [2:0] CMP_ADDR = RA_CMPA + 3'(c);

        assign ld_cmp[c] = wr_hit[CMP_ADDR] && en;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_sh_q[c] <= '0;
            end else if (ld_cmp[c]) begin
                cmp_sh_q[c] <= bus_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_act_q[c] <= '0;
            end else if (!running || (tick && wrap)) begin
                cmp_act_q[c] <= cmp_sh_q[c];
            end
        end
    end

    // ---------------- write-completion flags ----------------
    assign flag_start = {ld_cmp, ld_rld};

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        lpt_wrflag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (stop_req),
            .start_i (flag_start[f]),
            .tick_i  (tick),
            .clear_i (wr_hit[RA_CLEAR] && bus_wdata[f]),
            .flag_o  (flags[f])
        );
    end

    // ---------------- output channels ----------------
    if (SINGLE_OUT) begin : g_single
        assign chm_q    = '0;
        assign chm_busy = 1'b0;

        lpt_chan #(.CNT_W(CNT_W)) u_ch (
            .cnt_i (cnt_q),
            .cmp_i (cmp_act_q[0]),
            .en_i  (1'b1),
            .pol_i (opol_q),
            .out_o (pwm_a)
        );
        assign pwm_b = 1'b0;
    end else begin : g_dual
        logic              chm_arm;
        logic [NUM_CH-1:0] pwm_vec;

        assign chm_arm = wr_hit[RA_CHMODE] && !chm_busy;

        lpt_chm_guard u_guard (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (chm_arm),
            .psc_i  (psc_q),
            .busy_o (chm_busy)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chm_q <= '0;
            end else if (chm_arm) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    chm_q[2*c] <= bus_wdata[2*c];
                    if (!chm_q[2*c]) chm_q[2*c+1] <= bus_wdata[2*c+1];
                end
            end
        end

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            lpt_chan #(.CNT_W(CNT_W)) u_ch (
                .cnt_i (cnt_q),
                .cmp_i (cmp_act_q[c]),
                .en_i  (chm_q[2*c]),
                .pol_i (chm_q[2*c+1]),
                .out_o (pwm_vec[c])
            );
        end

        assign pwm_a = pwm_vec[0];
        assign pwm_b = pwm_vec[1];
    end

    // ---------------- read port ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_CTRL:   bus_rdata[1:0]          = {running, en};
            RA_CFG:    bus_rdata[PSC_W:0]      = {opol_q, psc_q};
            RA_RELOAD: bus_rdata               = rld_sh_q;
            RA_CMPA:   bus_rdata               = cmp_sh_q[0];
            RA_CMPB:   bus_rdata               = cmp_sh_q[1];
            RA_CHMODE: bus_rdata[CHM_W-1:0]    = chm_q;
            RA_STATUS: bus_rdata[NUM_FLAG:0]   = {chm_busy, flags};
            RA_CLEAR:  bus_rdata               = '0;
            default:   bus_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [2:0]          bus_addr,
    input logic [CNT_W-1:0]    bus_wdata,
    input tmr_state_e          state_q,
    input logic [CNT_W-1:0]    cnt_q,
    input logic [CNT_W-1:0]    rld_act_q,
    input logic [CNT_W-1:0]    rld_sh_q,
    input logic [PSC_W-1:0]    psc_q,
    input logic [2*NUM_CH-1:0] chm_q,
    input logic                chm_busy,
    input logic [NUM_FLAG-1:0] flags
);

    logic [NUM_FLAG-1:0] clr_now, keep_now;

    assign clr_now  = (bus_we && bus_addr == RA_CLEAR) ? bus_wdata[NUM_FLAG-1:0] : '0;
    assign keep_now = flags & ~clr_now;

    // R2: a stopped timer holds its counter at zero
    a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_OFF) |-> (cnt_q == '0));

    // R4: the counter never passes the reload value in use
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= rld_act_q);

    // R6: configuration stays put while enabled
    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TS_OFF) |=> $stable(psc_q));

    // R7: reload value stays put while disabled
    a_r7_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_OFF) |=> $stable(rld_sh_q));

    // R9: a set flag that is not cleared stays set
    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_now != '0) |=> ((flags & $past(keep_now)) == $past(keep_now)));

    // R13: the channel-mode register is frozen while the guard is busy
    a_r13_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        chm_busy |=> $stable(chm_q));

endmodule

bind lpt_timer lpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .rld_act_q (rld_act_q),
    .rld_sh_q  (rld_sh_q),
    .psc_q     (psc_q),
    .chm_q     (chm_q),
    .chm_busy  (chm_busy),
    .flags     (flags)
);

// File: tb/lpt_timer_tb.sv
module lpt_timer_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] rdata, rdata_s;
    logic         pwm_a, pwm_b, s_pwm_a, s_pwm_b;

    int n_cmp = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    lpt_timer #(.CNT_W(W), .SINGLE_OUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pwm_a(pwm_a), .pwm_b(pwm_b));

    lpt_timer #(.CNT_W(W), .SINGLE_OUT(1'b1)) u_dut_s (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .pwm_a(s_pwm_a), .pwm_b(s_pwm_b));

    // ---------------- behavioural reference ----------------
    int m_state = 0, m_psc = 0, m_opol = 0, m_div = 0, m_cnt = 0;
    int m_rld_sh = 0, m_rld_act = 0, m_chm = 0, m_busy = 0;
    int m_cmp_sh[2] = '{0, 0};
    int m_cmp_act[2] = '{0, 0};
    int m_pend[3] = '{0, 0, 0};
    int m_flag[3] = '{0, 0, 0};

    always @(posedge clk) begin : p_model
        int en, run, tick, stop, wrap, w, a, d, n_cnt, n_div, setf;
        if (!rst_n) begin
            m_state = 0; m_psc = 0; m_opol = 0; m_div = 0; m_cnt = 0;
            m_rld_sh = 0; m_rld_act = 0; m_chm = 0; m_busy = 0;
            for (int i = 0; i < 2; i++) begin m_cmp_sh[i] = 0; m_cmp_act[i] = 0; end
            for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_flag[i] = 0; end
        end else begin
            en   = (m_state != 0);
            run  = (m_state == 2);
            tick = en && (m_div == (1 << m_psc) - 1);
            w    = bus_we;
            a    = bus_addr;
            d    = bus_wdata;
            stop = w && a == 0 && !d[0];
            wrap = (m_cnt == m_rld_act);
            n_div = (!en || tick) ? 0 : m_div + 1;
            n_cnt = (!run || stop) ? 0 : (tick ? (wrap ? 0 : m_cnt + 1) : m_cnt);
            if (!run || (tick && wrap)) begin
                m_rld_act = m_rld_sh;
                for (int i = 0; i < 2; i++) m_cmp_act[i] = m_cmp_sh[i];
            end
            for (int i = 0; i < 3; i++) begin
                setf = 0;
                if (stop) m_pend[i] = 0;
                else if (en && w && a == 2 + i) m_pend[i] = 2;
                else if (tick && m_pend[i] > 0) begin
                    m_pend[i]--;
                    if (m_pend[i] == 0) setf = 1;
                end
                if (setf) m_flag[i] = 1;
                else if (w && a == 7 && d[i]) m_flag[i] = 0;
            end
            if (en && w && a == 2) m_rld_sh = d;
            if (en && w && a == 3) m_cmp_sh[0] = d;
            if (en && w && a == 4) m_cmp_sh[1] = d;
            if (w && a == 5 && m_busy == 0) begin
                for (int c = 0; c < 2; c++) begin
                    if (((m_chm >> (2*c)) & 1) == 0)
                        m_chm = (m_chm & ~(1 << (2*c+1))) | (d & (1 << (2*c+1)));
                    m_chm = (m_chm & ~(1 << (2*c))) | (d & (1 << (2*c)));
                end
                m_busy = 3 << m_psc;
            end else if (m_busy > 0) begin
                m_busy--;
            end
            if (!en && w && a == 1) begin m_psc = d & 7; m_opol = (d >> 3) & 1; end
            if (w && a == 0) begin
                case (m_state)
                    0: if (d[0]) m_state = 1;
                    1: if (!d[0]) m_state = 0; else if (d[1]) m_state = 2;
                    default: if (!d[0]) m_state = 0;
                endcase
            end
            m_cnt = n_cnt;
            m_div = n_div;
        end
    end

    function automatic int m_out(int c);
        int ce, cp, act;
        ce  = (m_chm >> (2*c)) & 1;
        cp  = (m_chm >> (2*c+1)) & 1;
        act = (m_cnt > m_cmp_act[c]) ? 1 : 0;
        return ce ? (act ^ cp) : cp;
    endfunction

    function automatic int m_rd(int a);
        case (a)
            0: return ((m_state == 2) ? 2 : 0) | ((m_state != 0) ? 1 : 0);
            1: return (m_opol << 3) | m_psc;
            2: return m_rld_sh;
            3: return m_cmp_sh[0];
            4: return m_cmp_sh[1];
            5: return m_chm;
            6: return ((m_busy > 0) ? 8 : 0) | (m_flag[2] << 2) | (m_flag[1] << 1) | m_flag[0];
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        case (a)
            0: return "R2";
            1: return "R6";
            2: return "R7 R10";
            3: return "R7";
            4: return "R7";
            5: return "R12 R13";
            6: return "R8 R9 R13";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(pwm_a), m_out(0), "R3 R4 R5 R10 R11 R12");
            check(int'(pwm_b), m_out(1), "R3 R4 R5 R10 R11 R12");
            check(int'(rdata), m_rd(bus_addr), rd_tag(bus_addr));
            check(int'(s_pwm_a), ((m_cnt > m_cmp_act[0]) ? 1 : 0) ^ m_opol, "R14");
            check(int'(s_pwm_b), 0, "R14");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(posedge clk); #3;
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = W'(d);
        @(posedge clk); #3;
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        @(posedge clk); #3;
        bus_addr = 3'(a);
        @(negedge clk);
        check(int'(rdata), exp, tag);
    endtask

    task automatic measure(input int n, output int ha, output int hb, output int hs);
        ha = 0; hb = 0; hs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
            hs += int'(s_pwm_a);
        end
    endtask

    initial begin : p_watchdog
        #(2_000_000);
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin : p_main
        int ha, hb, hs;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;

        // R1: reset state of all registers and outputs
        for (int a = 0; a < 8; a++) rd_check(a, 0, "R1");
        @(negedge clk);
        check(int'(pwm_a), 0, "R1");
        check(int'(pwm_b), 0, "R1");

        // prescale 2, reload 9, compares 6 and 3
        wr(1, 1);
        wr(0, 1);
        wr(2, 9);
        wr(3, 6);
        wr(4, 3);
        repeat (10) @(posedge clk);
        rd_check(6, 7, "R8");
        wr(5, 5);
        repeat (8) @(posedge clk);
        wr(0, 3);
        rd_check(0, 3, "R2");
        repeat (40) @(posedge clk);
        measure(40, ha, hb, hs);
        check(ha, 12, "R4 R5");
        check(hb, 24, "R4 R5");
        check(hs, 12, "R14");

        // R6: configuration write while enabled
        wr(1, 5);
        rd_check(1, 1, "R6");

        // R10: reload change while counting
        wr(2, 4);
        repeat (30) @(posedge clk);

        // R9: clear only compare-A flag
        wr(7, 2);
        rd_check(6, 5, "R9");

        // R12 / R13: polarity lock and write guard
        wr(5, 7);
        wr(5, 1);
        rd_check(5, 5, "R12 R13");
        repeat (10) @(posedge clk);
        wr(5, 4);
        repeat (10) @(posedge clk);
        wr(5, 7);
        rd_check(5, 7, "R12");
        repeat (30) @(posedge clk);

        // R2 / R7: stop, then reload write while disabled
        wr(0, 0);
        rd_check(0, 0, "R2");
        wr(2, 20);
        rd_check(2, 4, "R7");

        // R3 / R14: largest prescale, single-output polarity from bit3
        wr(1, 15);
        wr(0, 1);
        wr(2, 1);
        wr(3, 0);
        wr(0, 3);
        repeat (300) @(posedge clk);
        measure(512, ha, hb, hs);
        check(ha, 256, "R3 R11");
        check(hb, 0, "R11");
        check(hs, 256, "R3 R14");

        repeat (5) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule